// File: doc/BRIEF.md
# FIFO Demand-Mode DMA Sequencer

This block sequences a single DMA channel that moves bytes between an on-chip FIFO and a far endpoint. FIFO status paces the transfers. The channel is armed by a GO pulse, which loads a byte count and a direction. In the inbound direction, bytes are popped from the input FIFO and written to the far endpoint. In the outbound direction, bytes are read from the far endpoint and pushed into the output FIFO. Each byte takes a read strobe, then a write strobe on the next cycle, and the byte is carried in a register between the two.

Each FIFO has a service-request flag, and transfers run only while that flag is set. A trigger bit picks the condition that sets each flag:
- The input flag is set on "not empty", or only on "full".
- The output flag is set on "not full", or only on "empty".

Once set, a flag stays set until its FIFO reaches the opposite extreme: empty for the input FIFO, full for the output FIFO. A burst started by a full input FIFO therefore drains it completely.

A command byte at the input FIFO head pauses inbound transfers and raises a command interrupt. The transfers resume once software has read that byte. When the byte count reaches zero, the channel disarms, sets DONE and pulses a completion interrupt. A FIFO service interrupt is raised only when a request is pending while the channel is not armed.

Top module: `fifo_dma_seq`

## Requirements
- R1: After synchronous reset, all four strobes, `done`, `dma_irq`, `cmd_irq` and `svc_irq` are 0, and `count_left` is 0.
- R2: Every transferred byte is one read strobe (`in_pop` or `far_rd`) followed in the very next cycle by one write strobe (`far_wr` or `out_push`). `xfer_data` carries the byte read. Bytes leave in the order they were read. `count_left` decreases by exactly one per write strobe.
- R3: With `cfg_dir_out`=0 and `in_trig_full`=0, transfers start as soon as the input FIFO holds a byte and stop when it is empty.
- R4: With `in_trig_full`=1, no byte is popped while the input FIFO is neither full nor already requested. Once it has been full, transfers continue until it is empty, even though it is no longer full.
- R5: With `cfg_dir_out`=1 and `out_trig_empty`=0, bytes are read from the far endpoint and pushed into the output FIFO while it is not full. Transfers stop when it is full.
- R6: With `out_trig_empty`=1, a partly drained output FIFO receives nothing until it is empty. It is then filled until full.
- R7: When the input FIFO head is flagged as a command (`in_head_cmd`=1), it is not popped, and `cmd_irq` rises and stays 1. Inbound transfers stay paused until a `cmd_read` pulse, which clears `cmd_irq`. Transfers then resume with the byte after the command.
- R8: When the write strobe of the last counted byte completes, `done` goes to 1, `dma_irq` is high for exactly one cycle, and the channel disarms. No further strobes occur, even if the FIFO still holds data.
- R9: `svc_irq` is 0 throughout armed transfers. It is 1 when the selected FIFO's request flag is set while the channel is disarmed.
- R10: At most one strobe is active per cycle. `in_pop` never occurs while the input FIFO is empty, and `out_push` never occurs while the output FIFO is full.
- R11: A GO pulse with `cfg_count`=0 sets `done` and pulses `dma_irq` on the next cycle, without any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_set | input | 1 | Arm pulse; loads direction and count (honoured between bytes) |
| cfg_dir_out | input | 1 | 0: input FIFO to far endpoint; 1: far endpoint to output FIFO |
| cfg_count | input | CW | Number of bytes to move |
| in_trig_full | input | 1 | Input request on full (1) or on not-empty (0) |
| out_trig_empty | input | 1 | Output request on empty (1) or on not-full (0) |
| in_empty | input | 1 | Input FIFO empty |
| in_full | input | 1 | Input FIFO full |
| in_head_cmd | input | 1 | Input FIFO head entry is a command byte |
| in_rdata | input | DW | Input FIFO head data |
| cmd_read | input | 1 | Software has read the command byte at the head |
| far_rdata | input | DW | Far endpoint read data |
| out_empty | input | 1 | Output FIFO empty |
| out_full | input | 1 | Output FIFO full |
| in_pop | output | 1 | Pop strobe to input FIFO |
| far_wr | output | 1 | Write strobe to far endpoint |
| far_rd | output | 1 | Read strobe to far endpoint |
| out_push | output | 1 | Push strobe to output FIFO |
| xfer_data | output | DW | Byte held between read and write |
| count_left | output | CW | Remaining byte count |
| done | output | 1 | Count exhausted |
| dma_irq | output | 1 | One-cycle completion interrupt |
| cmd_irq | output | 1 | Command byte pending at input head |
| svc_irq | output | 1 | FIFO service request not handled by DMA |

## Verification
The assertions take the following for granted about the environment:
- The FIFO flags change only at clock edges.
- They reflect a pop or a push by the following cycle.
- `cmd_read` is pulsed only while `cmd_irq` is set.
- `go_set` is issued only while the channel is idle.

The stimulus meets these conditions by modelling both FIFOs in the bench as four-entry registers that update on the same edge as the strobes, by pushing only when the input FIFO has room, and by draining the output FIFO only from bench tasks. Expected bytes come from the push order and from an incrementing far-endpoint pattern, never from the design.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
  typedef enum logic [1:0] {
    PH_CHK = 2'd0,
    PH_RD  = 2'd1,
    PH_WR  = 2'd2
  } phase_e;
endpackage

// File: rtl/fdma_req_flag.sv
module fdma_req_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic req_o
);
  always_ff @(posedge clk) begin
    if (rst)        req_o <= 1'b0;
    else if (clr_i) req_o <= 1'b0;
    else if (set_i) req_o <= 1'b1;
  end

  // R4
  req_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o && !clr_i) |=> req_o);
endmodule

// File: rtl/fdma_ctrl.sv
module fdma_ctrl
  import fdma_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_set,
  input  logic          cfg_dir_out,
  input  logic [CW-1:0] cfg_count,
  input  logic          in_req,
  input  logic          out_req,
  input  logic          in_empty,
  input  logic          out_full,
  input  logic          in_head_cmd,
  input  logic          cmd_read,
  input  logic [DW-1:0] in_rdata,
  input  logic [DW-1:0] far_rdata,
  output phase_e        phase_q,
  output logic          dir_q,
  output logic          go_q,
  output logic [CW-1:0] cnt_q,
  output logic          done_q,
  output logic          dma_irq_q,
  output logic          cmd_irq_q,
  output logic [DW-1:0] byte_q
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic can_in, start_in, hit_cmd, start_out, last_byte;

  always_comb begin
    can_in    = go_q && !dir_q && in_req && !in_empty && !cmd_irq_q;
    start_in  = can_in && !in_head_cmd;
    hit_cmd   = can_in && in_head_cmd && (phase_q == PH_CHK);
    start_out = go_q && dir_q && out_req && !out_full;
    last_byte = (cnt_q == CNT_ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_CHK;
      dir_q     <= 1'b0;
      go_q      <= 1'b0;
      cnt_q     <= '0;
      done_q    <= 1'b0;
      dma_irq_q <= 1'b0;
      byte_q    <= '0;
    end else begin
      dma_irq_q <= 1'b0;
      unique case (phase_q)
        PH_CHK: begin
          if (go_set) begin
            dir_q     <= cfg_dir_out;
            cnt_q     <= cfg_count;
            go_q      <= (cfg_count != '0);
            done_q    <= (cfg_count == '0);
            dma_irq_q <= (cfg_count == '0);
          end else if (start_in || start_out) begin
            phase_q <= PH_RD;
          end
        end
        PH_RD: begin
          byte_q  <= dir_q ? far_rdata : in_rdata;
          phase_q <= PH_WR;
        end
        PH_WR: begin
          cnt_q   <= cnt_q - CNT_ONE;
          phase_q <= PH_CHK;
          if (last_byte) begin
            go_q      <= 1'b0;
            done_q    <= 1'b1;
            dma_irq_q <= 1'b1;
          end
        end
        default: phase_q <= PH_CHK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           cmd_irq_q <= 1'b0;
    else if (cmd_read) cmd_irq_q <= 1'b0;
    else if (hit_cmd)  cmd_irq_q <= 1'b1;
  end

  // R8
  dma_irq_done_chk: assert property (@(posedge clk) disable iff (rst)
    dma_irq_q |-> (done_q && !go_q));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !go_q) |-> (phase_q == PH_CHK || $past(go_q)));
  // R7
  cmd_block_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_irq_q && phase_q == PH_CHK) |=> (phase_q == PH_CHK || dir_q));
endmodule

// File: rtl/fifo_dma_seq.sv
module fifo_dma_seq
  import fdma_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_set,
  input  logic          cfg_dir_out,
  input  logic [CW-1:0] cfg_count,
  input  logic          in_trig_full,
  input  logic          out_trig_empty,
  input  logic          in_empty,
  input  logic          in_full,
  input  logic          in_head_cmd,
  input  logic [DW-1:0] in_rdata,
  input  logic          cmd_read,
  input  logic [DW-1:0] far_rdata,
  input  logic          out_empty,
  input  logic          out_full,
  output logic          in_pop,
  output logic          far_wr,
  output logic          far_rd,
  output logic          out_push,
  output logic [DW-1:0] xfer_data,
  output logic [CW-1:0] count_left,
  output logic          done,
  output logic          dma_irq,
  output logic          cmd_irq,
  output logic          svc_irq
);
  localparam int NREQ = 2;

  phase_e          phase_q;
  logic            dir_q, go_q, done_q, dma_irq_q, cmd_irq_q, svc_q;
  logic [CW-1:0]   cnt_q;
  logic [DW-1:0]   byte_q;
  logic [NREQ-1:0] req_set, req_clr, req_q;

  always_comb begin
    req_set[0] = in_trig_full ? in_full : !in_empty;
    req_clr[0] = in_empty;
    req_set[1] = out_trig_empty ? out_empty : !out_full;
    req_clr[1] = out_full;
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    fdma_req_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (req_set[g]),
      .clr_i (req_clr[g]),
      .req_o (req_q[g])
    );
  end

  fdma_ctrl #(.CW(CW), .DW(DW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .go_set      (go_set),
    .cfg_dir_out (cfg_dir_out),
    .cfg_count   (cfg_count),
    .in_req      (req_q[0]),
    .out_req     (req_q[1]),
    .in_empty    (in_empty),
    .out_full    (out_full),
    .in_head_cmd (in_head_cmd),
    .cmd_read    (cmd_read),
    .in_rdata    (in_rdata),
    .far_rdata   (far_rdata),
    .phase_q     (phase_q),
    .dir_q       (dir_q),
    .go_q        (go_q),
    .cnt_q       (cnt_q),
    .done_q      (done_q),
    .dma_irq_q   (dma_irq_q),
    .cmd_irq_q   (cmd_irq_q),
    .byte_q      (byte_q)
  );

  always_ff @(posedge clk) begin
    if (rst) svc_q <= 1'b0;
    else     svc_q <= (dir_q ? req_q[1] : req_q[0]) && !go_q;
  end

  always_comb begin
    in_pop     = (phase_q == PH_RD) && !dir_q;
    far_rd     = (phase_q == PH_RD) &&  dir_q;
    far_wr     = (phase_q == PH_WR) && !dir_q;
    out_push   = (phase_q == PH_WR) &&  dir_q;
    xfer_data  = byte_q;
    count_left = cnt_q;
    done       = done_q;
    dma_irq    = dma_irq_q;
    cmd_irq    = cmd_irq_q;
    svc_irq    = svc_q;
  end

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({in_pop, far_wr, far_rd, out_push}));
  // R10
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    in_pop |-> !in_empty);
  // R10
  no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
    out_push |-> !out_full);
  // R2
  in_pair_chk: assert property (@(posedge clk) disable iff (rst)
    in_pop |=> far_wr);
  // R5
  out_pair_chk: assert property (@(posedge clk) disable iff (rst)
    far_rd |=> out_push);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (far_wr || out_push) |=> (count_left == $past(count_left) - CW'(1)));
  // R9
  svc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (in_pop || far_wr || far_rd || out_push) |-> !svc_irq);
  // R7
  cmd_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_irq |-> !in_pop);
endmodule

// File: tb/fifo_dma_seq_tb.sv
module fifo_dma_seq_tb;
  localparam int CW = 8;
  localparam int DW = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          go_set = 0, cfg_dir_out = 0, in_trig_full = 0, out_trig_empty = 0;
  logic [CW-1:0] cfg_count = '0;
  logic          cmd_read = 0;
  logic          in_empty, in_full, in_head_cmd, out_empty, out_full;
  logic [DW-1:0] in_rdata, far_rdata;
  logic          in_pop, far_wr, far_rd, out_push, done, dma_irq, cmd_irq, svc_irq;
  logic [DW-1:0] xfer_data;
  logic [CW-1:0] count_left;

  logic          tb_push = 0, tb_push_cmd = 0, tb_out_pop = 0;
  logic [DW-1:0] tb_push_data = '0;
  logic [DW-1:0] in_mem [DEPTH];
  logic          in_cmd [DEPTH];
  int            ir, iw, icnt, ocnt, n_far;
  logic [DW-1:0] exp_mem [64];
  int            exp_w = 0, exp_r = 0;
  int            n_wr = 0, n_push = 0, n_dma = 0;
  logic          prev_pop = 0, prev_frd = 0;
  int            checks = 0, fails = 0;

  fifo_dma_seq #(.CW(CW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .go_set(go_set), .cfg_dir_out(cfg_dir_out),
    .cfg_count(cfg_count), .in_trig_full(in_trig_full), .out_trig_empty(out_trig_empty),
    .in_empty(in_empty), .in_full(in_full), .in_head_cmd(in_head_cmd),
    .in_rdata(in_rdata), .cmd_read(cmd_read), .far_rdata(far_rdata),
    .out_empty(out_empty), .out_full(out_full), .in_pop(in_pop), .far_wr(far_wr),
    .far_rd(far_rd), .out_push(out_push), .xfer_data(xfer_data),
    .count_left(count_left), .done(done), .dma_irq(dma_irq), .cmd_irq(cmd_irq),
    .svc_irq(svc_irq)
  );

  // FIFO and far-endpoint models
  always @(posedge clk) begin
    if (rst) begin
      ir <= 0; iw <= 0; icnt <= 0; ocnt <= 0; n_far <= 0;
    end else begin
      if (tb_push) begin
        in_mem[iw] <= tb_push_data;
        in_cmd[iw] <= tb_push_cmd;
        iw <= (iw + 1) % DEPTH;
      end
      if (in_pop || cmd_read) ir <= (ir + 1) % DEPTH;
      icnt <= icnt + int'(tb_push) - int'(in_pop || cmd_read);
      ocnt <= ocnt + int'(out_push) - int'(tb_out_pop);
      if (far_rd) n_far <= n_far + 1;
    end
  end

  assign in_empty    = (icnt == 0);
  assign in_full     = (icnt == DEPTH);
  assign in_rdata    = in_mem[ir];
  assign in_head_cmd = (icnt != 0) && in_cmd[ir];
  assign out_empty   = (ocnt == 0);
  assign out_full    = (ocnt == DEPTH);
  assign far_rdata   = 8'hA0 + DW'(n_far);

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Strobe monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (far_wr) begin
        n_wr++;
        check(prev_pop, "R2 pop before write", int'(prev_pop), 1);
        check(xfer_data == exp_mem[exp_r], "R2 byte order", int'(xfer_data), int'(exp_mem[exp_r]));
        exp_r++;
      end
      if (out_push) begin
        check(prev_frd, "R5 read before push", int'(prev_frd), 1);
        check(xfer_data == 8'hA0 + DW'(n_push), "R5 byte order", int'(xfer_data), 8'hA0 + n_push);
        n_push++;
      end
      if (in_pop || far_wr || far_rd || out_push)
        check(!svc_irq, "R9 svc quiet", int'(svc_irq), 0);
      check($countones({in_pop, far_wr, far_rd, out_push}) <= 1, "R10 onehot",
            $countones({in_pop, far_wr, far_rd, out_push}), 1);
      if (in_pop) check(!in_empty, "R10 pop empty", int'(in_empty), 0);
      if (dma_irq) n_dma++;
      prev_pop = in_pop;
      prev_frd = far_rd;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] d, input logic is_cmd);
    tb_push = 1; tb_push_data = d; tb_push_cmd = is_cmd;
    if (!is_cmd) begin exp_mem[exp_w] = d; exp_w++; end
    @(negedge clk);
    tb_push = 0; tb_push_cmd = 0;
  endtask

  task automatic drain(input int n);
    for (int k = 0; k < n; k++) begin
      tb_out_pop = 1; @(negedge clk);
    end
    tb_out_pop = 0;
  endtask

  task automatic go(input logic dir, input int cnt);
    go_set = 1; cfg_dir_out = dir; cfg_count = CW'(cnt);
    @(negedge clk);
    go_set = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    cyc(3); rst = 0; cyc(1);
    // R1 reset state
    check({in_pop, far_wr, far_rd, out_push} == 0, "R1 strobes", 0, 0);
    check({done, dma_irq, cmd_irq, svc_irq} == 0, "R1 flags",
          int'({done, dma_irq, cmd_irq, svc_irq}), 0);
    check(count_left == 0, "R1 count", int'(count_left), 0);

    // R11 zero count
    go(0, 0);
    check(done && dma_irq, "R11 done pulse", int'({done, dma_irq}), 3);
    cyc(1);
    check(!dma_irq, "R11 pulse width", int'(dma_irq), 0);
    check(n_wr == 0, "R11 no strobe", n_wr, 0);

    // R3 not-empty trigger, R2 count
    go(0, 10);
    check(!done, "R3 done cleared", int'(done), 0);
    push(8'h11, 0); push(8'h12, 0); push(8'h13, 0);
    cyc(20);
    check(n_wr == 3, "R3 bytes moved", n_wr, 3);
    check(count_left == 7, "R2 count", int'(count_left), 7);
    check(in_empty, "R3 stop on empty", int'(in_empty), 1);
    push(8'h14, 0); push(8'h15, 0);
    cyc(20);
    check(n_wr == 5, "R3 resume", n_wr, 5);

    // R7 command byte pause
    push(8'h21, 0); push(8'hC1, 1); push(8'h22, 0);
    cyc(20);
    check(n_wr == 6, "R7 stop at command", n_wr, 6);
    check(cmd_irq, "R7 cmd irq", int'(cmd_irq), 1);
    check(count_left == 4, "R7 count", int'(count_left), 4);
    cyc(10);
    check(n_wr == 6 && cmd_irq, "R7 held", n_wr, 6);
    cmd_read = 1; @(negedge clk); cmd_read = 0;
    check(!cmd_irq, "R7 cleared", int'(cmd_irq), 0);
    cyc(20);
    check(n_wr == 7, "R7 resumed", n_wr, 7);

    // R8 count reaches zero with data left
    push(8'h31, 0); push(8'h32, 0); push(8'h33, 0); push(8'h34, 0);
    cyc(20);
    check(n_wr == 10, "R8 stop at count", n_wr, 10);
    check(done && count_left == 0, "R8 done", int'(count_left), 0);
    check(n_dma == 2, "R8 irq pulses", n_dma, 2);
    check(icnt == 1, "R8 data left", icnt, 1);
    check(svc_irq, "R9 svc after done", int'(svc_irq), 1);

    // R4 full trigger, sticky until empty
    in_trig_full = 1;
    go(0, 6);
    cyc(20);
    check(n_wr == 11, "R4 sticky leftover", n_wr, 11);
    push(8'h41, 0); push(8'h42, 0); push(8'h43, 0);
    cyc(20);
    check(n_wr == 11, "R4 waits for full", n_wr, 11);
    push(8'h44, 0);
    cyc(20);
    check(n_wr == 15, "R4 drains all", n_wr, 15);
    check(count_left == 1, "R4 count", int'(count_left), 1);
    push(8'h51, 0);
    cyc(20);
    check(n_wr == 15, "R4 cleared on empty", n_wr, 15);
    push(8'h52, 0); push(8'h53, 0); push(8'h54, 0);
    cyc(20);
    check(n_wr == 16 && done, "R8 done in full mode", n_wr, 16);
    check(n_dma == 3, "R8 irq count", n_dma, 3);
    check(svc_irq, "R9 sticky request shown", int'(svc_irq), 1);

    // drain leftovers
    in_trig_full = 0;
    go(0, 3);
    cyc(25);
    check(n_wr == 19 && in_empty, "R3 leftovers", n_wr, 19);
    check(!svc_irq, "R9 idle empty", int'(svc_irq), 0);

    // R5 output direction, not-full trigger
    go(1, 20);
    cyc(25);
    check(n_push == 4 && out_full, "R5 fill to full", n_push, 4);
    check(count_left == 16, "R5 count", int'(count_left), 16);
    drain(1);
    cyc(15);
    check(n_push == 5, "R5 refill one", n_push, 5);

    // R6 empty trigger
    out_trig_empty = 1;
    drain(1);
    cyc(15);
    check(n_push == 5, "R6 waits for empty", n_push, 5);
    drain(3);
    cyc(25);
    check(n_push == 9 && out_full, "R6 fill after empty", n_push, 9);
    check(count_left == 11, "R6 count", int'(count_left), 11);

    finish_run();
  end
endmodule